// File: doc/BRIEF.md
# Power-Good Window Monitor

This block turns a digitized regulator feedback sample into a registered, active-high power-good flag. Each sample is compared against a reference code. There are two independent hysteresis bands, one over-voltage and one under-voltage. Each band has a trip level and a separate release level, and all levels are expressed in permille of the reference. A band's fault latch sets when its trip level is crossed. It stays set until the sample comes back past the release level, which lies closer to the reference.

The flag is gated by the regulator's control state. While the block is disabled or shutdown is asserted, the flag is low and everything the monitor has learned is discarded. After enable, the flag stays low until a soft-start completion indication arrives. That indication may be a one-cycle strobe or a level, and the block remembers it for as long as the regulator keeps running. The comparison uses exact integer products (sample × 1000 against reference × k), so no rounding step shifts a threshold.

Top module: `pgood_window`

## Requirements
- R1: Over-voltage band: with sample s and reference r, the over-voltage fault sets when s×1000 > r×1110. Once set, it clears only when s×1000 ≤ r×1075, and it holds for samples between those two levels.
- R2: Under-voltage band: the under-voltage fault sets when s×1000 < r×890. Once set, it clears only when s×1000 ≥ r×925, and it holds for samples between those two levels.
- R3: After enable, pwrGood stays low until ssDone has been seen high on at least one clock edge while running. A one-cycle ssDone strobe is remembered until enable drops or shutdown rises.
- R4: A clock edge that sees enable low drives pwrGood low on that same edge, with no filtering. It also clears both faults and forgets soft-start completion.
- R5: A clock edge that sees shutdown high has the same effect as enable low: pwrGood goes low, both faults clear, and soft-start completion is forgotten.
- R6: pwrGood is high exactly when the block is running, soft-start is complete, and neither fault is set. It reflects a sample on the same edge that captures that sample.
- R7: The fault states change only on edges where fbValid is high. Samples presented while fbValid is low have no effect.
- R8: Synchronous reset clears both faults and the soft-start memory, and drives pwrGood low.
- R9: The threshold products are formed at full width, so the comparisons stay exact at the largest sample and reference codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Regulator enable; low forces the flag low |
| ssDone | input | 1 | Soft-start completion, strobe or level |
| shutdown | input | 1 | Shutdown indication; high forces the flag low |
| fbValid | input | 1 | Qualifies fbSample on this edge |
| fbSample | input | W | Digitized feedback sample |
| refCode | input | W | Reference code |
| pwrGood | output | 1 | Registered power-good flag, active high |

## Verification
The bench sweeps the sample up through the whole code range and back down at several references, including the maximum code. It tracks the expected latch state arithmetically, so a design that uses one level for both trip and release, or that swaps strict and inclusive comparisons, fails at the exact boundary codes. One sweep drops fbValid on every third edge; a design that ignores the qualifier then changes state on unqualified samples. Directed cases pulse enable low and shutdown high for a single cycle, and hold a good sample before soft-start ends. A design that filters the disable, keeps stale faults or soft-start memory across a disable, or raises the flag before soft-start completes shows a wrong pwrGood on the next edge.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef struct packed {
    logic latchEn;
    logic clearAll;
  } pgw_strobe_t;

  typedef struct packed {
    logic ov;
    logic uv;
  } pgw_fault_t;
endpackage

// File: rtl/pgw_band.sv
module pgw_band
  import pgw_pkg::*;
#(
  parameter int W      = 10,
  parameter int SCALE  = 1000,
  parameter int TRIP_K = 1110,
  parameter int REL_K  = 1075,
  parameter bit ABOVE  = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  pgw_strobe_t strobe,
  input  logic [W-1:0] fbSample,
  input  logic [W-1:0] refCode,
  output logic        faultNext,
  output logic        faultQ
);
  localparam int KMAX = (TRIP_K > REL_K) ? ((TRIP_K > SCALE) ? TRIP_K : SCALE)
                                         : ((REL_K > SCALE) ? REL_K : SCALE);
  localparam int KW = $clog2(KMAX + 1);
  localparam int PW = W + KW;

  logic [PW-1:0] fbScaled, tripLvl, relLvl;
  logic tripHit, relHit;

  assign fbScaled = PW'(fbSample) * PW'(SCALE);
  assign tripLvl  = PW'(refCode) * PW'(TRIP_K);
  assign relLvl   = PW'(refCode) * PW'(REL_K);

  generate
    if (ABOVE) begin : g_over
      assign tripHit = fbScaled > tripLvl;
      assign relHit  = fbScaled <= relLvl;
    end else begin : g_under
      assign tripHit = fbScaled < tripLvl;
      assign relHit  = fbScaled >= relLvl;
    end
  endgenerate

  always_comb begin
    if (strobe.clearAll)      faultNext = 1'b0;
    else if (strobe.latchEn)  faultNext = faultQ ? !relHit : tripHit;
    else                      faultNext = faultQ;
  end

  always_ff @(posedge clk) begin
    if (rst) faultQ <= 1'b0;
    else     faultQ <= faultNext;
  end
endmodule

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  pgw_strobe_t  strobe,
  input  logic [W-1:0] fbSample,
  input  logic [W-1:0] refCode,
  output pgw_fault_t   faultNx,
  output pgw_fault_t   faultQ
);
  pgw_band #(.W(W), .SCALE(1000), .TRIP_K(1110), .REL_K(1075), .ABOVE(1'b1)) u_over (
    .clk(clk), .rst(rst), .strobe(strobe), .fbSample(fbSample), .refCode(refCode),
    .faultNext(faultNx.ov), .faultQ(faultQ.ov)
  );

  pgw_band #(.W(W), .SCALE(1000), .TRIP_K(890), .REL_K(925), .ABOVE(1'b0)) u_under (
    .clk(clk), .rst(rst), .strobe(strobe), .fbSample(fbSample), .refCode(refCode),
    .faultNext(faultNx.uv), .faultQ(faultQ.uv)
  );
endmodule

// File: rtl/pgw_control.sv
module pgw_control
  import pgw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        shutdown,
  input  logic        ssDone,
  input  logic        fbValid,
  input  pgw_fault_t  faultNx,
  output pgw_strobe_t strobe,
  output logic        pwrGood
);
  logic runOk, ssArmed, ssArmedNext;

  assign runOk           = enable && !shutdown;
  assign strobe.clearAll = !runOk;
  assign strobe.latchEn  = fbValid;
  assign ssArmedNext     = runOk && (ssArmed || ssDone);

  always_ff @(posedge clk) begin
    if (rst) begin
      ssArmed <= 1'b0;
      pwrGood <= 1'b0;
    end else begin
      ssArmed <= ssArmedNext;
      pwrGood <= ssArmedNext && !faultNx.ov && !faultNx.uv;
    end
  end
endmodule

// File: rtl/pgood_window.sv
module pgood_window
  import pgw_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         ssDone,
  input  logic         shutdown,
  input  logic         fbValid,
  input  logic [W-1:0] fbSample,
  input  logic [W-1:0] refCode,
  output logic         pwrGood
);
  pgw_strobe_t strobe;
  pgw_fault_t  faultNx, faultQ;

  pgw_control u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .shutdown(shutdown), .ssDone(ssDone),
    .fbValid(fbValid), .faultNx(faultNx), .strobe(strobe), .pwrGood(pwrGood)
  );

  pgw_datapath #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .fbSample(fbSample), .refCode(refCode),
    .faultNx(faultNx), .faultQ(faultQ)
  );
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         enable,
  input logic         shutdown,
  input logic         fbValid,
  input logic [W-1:0] fbSample,
  input logic [W-1:0] refCode,
  input logic         ovQ,
  input logic         uvQ,
  input logic         pwrGood
);
  localparam int PW = W + 12;
  logic [PW-1:0] sScaled, ovTrip, uvTrip;
  assign sScaled = PW'(fbSample) * PW'(1000);
  assign ovTrip  = PW'(refCode) * PW'(1110);
  assign uvTrip  = PW'(refCode) * PW'(890);

  AST_OV_TRIP: assert property (@(posedge clk) disable iff (rst)
    (fbValid && enable && !shutdown && sScaled > ovTrip) |=> ovQ);  // R1
  AST_UV_TRIP: assert property (@(posedge clk) disable iff (rst)
    (fbValid && enable && !shutdown && sScaled < uvTrip) |=> uvQ);  // R2
  AST_DISABLE_DROP: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!pwrGood && !ovQ && !uvQ));  // R4
  AST_SHUTDOWN_DROP: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (!pwrGood && !ovQ && !uvQ));  // R5
  AST_GOOD_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    pwrGood |-> (!ovQ && !uvQ));  // R6
  AST_HOLD_UNQUALIFIED: assert property (@(posedge clk) disable iff (rst)
    (!fbValid && enable && !shutdown) |=> ($stable(ovQ) && $stable(uvQ)));  // R7
endmodule

bind pgood_window pgw_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .shutdown(shutdown), .fbValid(fbValid),
  .fbSample(fbSample), .refCode(refCode), .ovQ(faultQ.ov), .uvQ(faultQ.uv),
  .pwrGood(pwrGood)
);

// File: tb/test_pgood_window.sv
module test_pgood_window;
  localparam int W = 10;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0, ssDone = 1'b0, shutdown = 1'b0, fbValid = 1'b0;
  logic [W-1:0] fbSample = '0, refCode = '0;
  logic pwrGood;

  int checks = 0, errors = 0;
  bit mOv = 0, mUv = 0, mSs = 0, mGood = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgood_window #(.W(W)) i_pgood_window (
    .clk(clk), .rst(rst), .enable(enable), .ssDone(ssDone), .shutdown(shutdown),
    .fbValid(fbValid), .fbSample(fbSample), .refCode(refCode), .pwrGood(pwrGood)
  );

  task automatic check(input string tag);
    checks++;
    if (pwrGood !== mGood) begin
      errors++;
      $display("FAIL %s: pwrGood=%0b expected=%0b (fb=%0d ref=%0d)", tag, pwrGood, mGood, fbSample, refCode);
    end
  endtask

  // Applies inputs before a rising edge, advances the model for that edge, checks after it.
  task automatic step(input bit en, input bit sd, input bit ss, input bit vld,
                      input int fb, input int rf, input string tag);
    longint s, r;
    bit run;
    @(negedge clk);
    enable = en; shutdown = sd; ssDone = ss; fbValid = vld;
    fbSample = W'(fb); refCode = W'(rf);
    s = longint'(fb) * 1000; r = longint'(rf);
    run = en && !sd;
    if (rst) begin
      mOv = 0; mUv = 0; mSs = 0;
    end else if (!run) begin
      mOv = 0; mUv = 0; mSs = 0;
    end else begin
      if (vld) begin
        mOv = mOv ? !(s <= r * 1075) : (s > r * 1110);
        mUv = mUv ? !(s >= r * 925) : (s < r * 890);
      end
      mSs = mSs || ss;
    end
    mGood = !rst && mSs && !mOv && !mUv;
    @(posedge clk);
    #1;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int refs[4] = '{600, 200, 917, 1023};
    // R8: reset state, with otherwise good conditions applied
    step(1, 0, 1, 1, 600, 600, "R8 reset");
    step(1, 0, 1, 1, 600, 600, "R8 reset hold");
    rst = 1'b0;
    // R3: in-window sample but no soft-start yet
    for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 600, 600, "R3 before soft-start");
    step(1, 0, 1, 1, 600, 600, "R3 strobe seen");
    step(1, 0, 0, 1, 600, 600, "R3 strobe remembered");
    // R4: single-cycle disable drops and forgets soft-start
    step(0, 0, 0, 1, 600, 600, "R4 disable");
    step(1, 0, 0, 1, 600, 600, "R4 soft-start forgotten");
    step(1, 0, 1, 1, 600, 600, "R4 rearm");
    // R5: single-cycle shutdown, and fault cleared by it
    step(1, 0, 1, 1, 700, 600, "R5 set ov fault");
    step(1, 1, 1, 1, 650, 600, "R5 shutdown");
    step(1, 0, 1, 1, 650, 600, "R5 fault cleared");
    // R4: disable clears an under-voltage fault
    step(1, 0, 1, 1, 500, 600, "R4 set uv fault");
    step(0, 0, 1, 1, 540, 600, "R4 disable with uv");
    step(1, 0, 1, 1, 540, 600, "R4 uv fault cleared");
    // R7: unqualified samples ignored
    step(1, 0, 1, 0, 10, 600, "R7 low sample ignored");
    step(1, 0, 1, 0, 1000, 600, "R7 high sample ignored");
    // R9: boundary at maximum reference: 1023*0.89 = 910.47, 1023*0.925 = 946.275
    step(1, 0, 1, 1, 911, MAXC, "R9 above uv trip");
    step(1, 0, 1, 1, 910, MAXC, "R9 uv trip");
    step(1, 0, 1, 1, 946, MAXC, "R9 below uv release");
    step(1, 0, 1, 1, 947, MAXC, "R9 uv release");
    // R1 R2 R6: full up/down sweeps; last pass drops fbValid every third edge (R7)
    for (int p = 0; p < 5; p++) begin
      int rf = refs[p % 4];
      for (int i = 0; i <= MAXC; i++)
        step(1, 0, 1, (p < 4) || (i % 3 != 0), i, rf, "R1 R2 R6 sweep up");
      for (int i = MAXC; i >= 0; i--)
        step(1, 0, 1, (p < 4) || (i % 3 != 0), i, rf, "R1 R2 R6 sweep down");
    end
    // R8: reset mid-run
    rst = 1'b1;
    step(1, 0, 1, 1, 600, 600, "R8 reset mid-run");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule